// File: doc/BRIEF.md
# Six-Channel Reloadable Down-Counter Timer Unit

This block is a memory-mapped peripheral with six independent down-counting timers. The timers are laid out as three identical pairs, and all of them sit behind a plain 32-bit register port. Each timer has four registers: a control word, a run word, a reload value and a read-only live count. Software loads a reload value, starts the timer and optionally forces a load. The timer then counts down one step per clock. When it passes through zero it reloads itself and raises a pending flag.

Shared registers cover the rest of the unit. A clock-control word can freeze the whole unit and lock out its registers. A constant identification word lets software confirm that the unit is present. A per-timer interrupt enable mask and a pending-flag register (write one to clear) decide which timers drive their own interrupt line.

The register port is a single-cycle access port, not a data stream, so it has no handshake. A write takes effect on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr` while `bus_en` is high and `bus_we` is low, and is zero otherwise.

Top module: `hex_timer_unit`

## Requirements
- R1: After reset, the clock-control word reads 0x0000_0001, and every timer register, the enable mask and the pending flags read 0. All interrupt outputs are low.
- R2: Address 0x08 always reads 0x0000_5900 (bits 15:8 hold 0x59), and writes to it have no effect.
- R3: Timer i (0..5) has a group base of 0x10 + (i/2)*0x20 + (i%2)*4. From that base, control is at +0x00, run at +0x08, reload at +0x10 and count at +0x18. Each timer's registers are independent of the others.
- R4: The control word keeps only bits 10, 8, 7, 6 and 2 (mask 0x5C4). Other bits read as 0, and the control word does not change how the timer counts.
- R5: In the run word, bit 0 starts the timer (1) or stops it (0). Writing bit 2 loads the reload value into the count on that same edge, whether or not the timer is running; this load has priority over counting and produces no wrap. A read of the run word returns only bit 0.
- R6: A running timer of an active unit decrements by one on each clock. On the clock after the count reaches 0, it reloads from its reload register and sets pending flag i. The period is therefore reload+1 clocks.
- R7: Clock control (0x00) keeps bits 8, 4 and 0 (mask 0x111). The unit is active only when bit 0 is 0 and bit 4 is 1. While bit 0 is 1, no count or flag changes, and every write except to 0x00 is ignored. While bit 4 is 0 and bit 0 is 0, counting stops but register writes are accepted.
- R8: The enable mask is at 0xF4, bits 5:0. Interrupt output i is high exactly when pending flag i and enable bit i are both set.
- R9: Pending flags are at 0xFC, bits 5:0. Writing 1 to a bit clears that flag and writing 0 leaves it unchanged. If a wrap and a clear of the same flag happen on the same edge, the flag stays set.
- R10: Reads of unmapped or non-word-aligned addresses (including 0xF8) return 0, and writes to them change nothing.
- R11: The count register is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 6 | Per-timer interrupt lines |

## Verification
The bench checks the wrap edge cycle by cycle: it reads the count through 5..0 and then expects the reload value together with the pending flag. A design with an off-by-one terminal count would flag one clock early or late. A clear and a wrap are forced onto the same edge, using a reload of 0 so the timer wraps every cycle; a design where the clear wins would drop a pending interrupt. The two lockout modes are kept apart: a disabled unit must reject a reload write, while a suspended unit must accept it but not count. The bench also aims writes at misaligned and unmapped addresses, and at a read-only count, so that a loose address decode shows up as corrupted neighbouring registers.

// File: rtl/hex_timer_pkg.sv
package hex_timer_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_RUN  = 2'd1,
    FLD_RLD  = 2'd2,
    FLD_CNT  = 2'd3
  } tmr_fld_e;

  localparam logic [7:0]  ADDR_CLC   = 8'h00;
  localparam logic [7:0]  ADDR_ID    = 8'h08;
  localparam logic [7:0]  ADDR_IEN   = 8'hF4;
  localparam logic [7:0]  ADDR_CAP   = 8'hFC;
  localparam logic [31:0] ID_WORD    = 32'h0000_5900;
  localparam logic [31:0] CTRL_KEEP  = 32'h0000_05C4;
  localparam logic [31:0] CLC_KEEP   = 32'h0000_0111;
  localparam logic [31:0] CLC_RESET  = 32'h0000_0001;
  localparam int          CLC_OFF    = 0;
  localparam int          CLC_WAKE   = 4;
  localparam int          RUN_GO     = 0;
  localparam int          RUN_LOAD   = 2;
  localparam int          PAIR_STEP  = 32;
  localparam int          GROUP_BASE = 16;
  localparam int          ODD_SKEW   = 4;
endpackage

// File: rtl/hex_timer_dec.sv
module hex_timer_dec
  import hex_timer_pkg::*;
#(
  parameter int N_TMR = 6
) (
  input  logic [7:0]       addr,
  output logic             hit_clc,
  output logic             hit_id,
  output logic             hit_ien,
  output logic             hit_cap,
  output logic [N_TMR-1:0] hit_tmr,
  output tmr_fld_e         fld
);
  logic [N_TMR-1:0][1:0] fld_each;

  assign hit_clc = (addr == ADDR_CLC);
  assign hit_id  = (addr == ADDR_ID);
  assign hit_ien = (addr == ADDR_IEN);
  assign hit_cap = (addr == ADDR_CAP);

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam logic [8:0] BASE = 9'(GROUP_BASE + (i / 2) * PAIR_STEP + (i % 2) * ODD_SKEW);
    logic [8:0] diff;
    assign diff        = {1'b0, addr} - BASE;
    assign hit_tmr[i]  = ~diff[8] && (diff[7:5] == 3'd0) && (diff[2:0] == 3'd0);
    assign fld_each[i] = diff[4:3];
  end

  always_comb begin
    fld = FLD_CTRL;
    for (int i = 0; i < N_TMR; i++) begin
      if (hit_tmr[i]) fld = tmr_fld_e'(fld_each[i]);
    end
  end
endmodule

// File: rtl/hex_timer_chan.sv
module hex_timer_chan
  import hex_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             wr_ctrl,
  input  logic             wr_run,
  input  logic             wr_rld,
  input  logic [31:0]      wdata,
  output logic [31:0]      ctrl_q,
  output logic             run_q,
  output logic [CNT_W-1:0] rld_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_o
);
  logic tick;
  logic load_req;
  logic at_zero;

  assign load_req = wr_run && wdata[RUN_LOAD];
  assign tick     = active && run_q;
  assign at_zero  = (cnt_q == '0);
  assign wrap_o   = tick && at_zero && !load_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
      rld_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & CTRL_KEEP;
      if (wr_rld)  rld_q  <= wdata[CNT_W-1:0];
      if (wr_run)  run_q  <= wdata[RUN_GO];
      if (load_req)      cnt_q <= rld_q;
      else if (tick)     cnt_q <= at_zero ? rld_q : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hex_timer_irq.sv
module hex_timer_irq #(
  parameter int N_TMR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ien,
  input  logic             wr_cap,
  input  logic [N_TMR-1:0] wbits,
  input  logic [N_TMR-1:0] wrap,
  output logic [N_TMR-1:0] en_q,
  output logic [N_TMR-1:0] cap_q,
  output logic [N_TMR-1:0] irq
);
  logic [N_TMR-1:0] clr;

  assign clr = wr_cap ? wbits : '0;
  assign irq = cap_q & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      cap_q <= '0;
    end else begin
      if (wr_ien) en_q <= wbits;
      cap_q <= (cap_q & ~clr) | wrap;
    end
  end
endmodule

// File: rtl/hex_timer_unit.sv
module hex_timer_unit
  import hex_timer_pkg::*;
#(
  parameter int N_PAIRS = 3,
  parameter int CNT_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [2*N_PAIRS-1:0] irq_o
);
  localparam int N_TMR = 2 * N_PAIRS;

  logic                        hit_clc, hit_id, hit_ien, hit_cap;
  logic [N_TMR-1:0]            hit_tmr;
  tmr_fld_e                    fld;
  logic                        wr_any, wr_ok, active;
  logic [31:0]                 clc_q;
  logic [N_TMR-1:0][31:0]      ctrl_q;
  logic [N_TMR-1:0]            run_q;
  logic [N_TMR-1:0][CNT_W-1:0] rld_q;
  logic [N_TMR-1:0][CNT_W-1:0] cnt_q;
  logic [N_TMR-1:0]            wrap;
  logic [N_TMR-1:0]            en_q, cap_q;

  assign wr_any = bus_en && bus_we;
  assign wr_ok  = wr_any && !clc_q[CLC_OFF];
  assign active = !clc_q[CLC_OFF] && clc_q[CLC_WAKE];

  hex_timer_dec #(.N_TMR(N_TMR)) u_dec (
    .addr    (bus_addr),
    .hit_clc (hit_clc),
    .hit_id  (hit_id),
    .hit_ien (hit_ien),
    .hit_cap (hit_cap),
    .hit_tmr (hit_tmr),
    .fld     (fld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  clc_q <= CLC_RESET;
    else if (wr_any && hit_clc)  clc_q <= bus_wdata & CLC_KEEP;
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_chan
    hex_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .wr_ctrl (wr_ok && hit_tmr[i] && (fld == FLD_CTRL)),
      .wr_run  (wr_ok && hit_tmr[i] && (fld == FLD_RUN)),
      .wr_rld  (wr_ok && hit_tmr[i] && (fld == FLD_RLD)),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_q[i]),
      .run_q   (run_q[i]),
      .rld_q   (rld_q[i]),
      .cnt_q   (cnt_q[i]),
      .wrap_o  (wrap[i])
    );
  end

  hex_timer_irq #(.N_TMR(N_TMR)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ien (wr_ok && hit_ien),
    .wr_cap (wr_ok && hit_cap),
    .wbits  (bus_wdata[N_TMR-1:0]),
    .wrap   (wrap),
    .en_q   (en_q),
    .cap_q  (cap_q),
    .irq    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (hit_clc)      bus_rdata = clc_q;
      else if (hit_id)  bus_rdata = ID_WORD;
      else if (hit_ien) bus_rdata[N_TMR-1:0] = en_q;
      else if (hit_cap) bus_rdata[N_TMR-1:0] = cap_q;
      else begin
        for (int i = 0; i < N_TMR; i++) begin
          if (hit_tmr[i]) begin
            case (fld)
              FLD_CTRL: bus_rdata = ctrl_q[i];
              FLD_RUN:  bus_rdata[0] = run_q[i];
              FLD_RLD:  bus_rdata[CNT_W-1:0] = rld_q[i];
              default:  bus_rdata[CNT_W-1:0] = cnt_q[i];
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/hex_timer_unit_chk.sv
module hex_timer_unit_chk #(
  parameter int N_PAIRS = 3,
  parameter int CNT_W   = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_en,
  input logic                           bus_we,
  input logic [7:0]                     bus_addr,
  input logic [31:0]                    bus_rdata,
  input logic [2*N_PAIRS-1:0]           irq_o,
  input logic [31:0]                    clc_q,
  input logic [2*N_PAIRS-1:0][CNT_W-1:0] cnt_q,
  input logic [2*N_PAIRS-1:0]           cap_q,
  input logic [2*N_PAIRS-1:0]           en_q
);
  localparam int N_TMR = 2 * N_PAIRS;

  AST_ID_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 8'h08) |-> (bus_rdata == 32'h0000_5900)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && (bus_addr == 8'hF8 || bus_addr[1:0] != 2'b00)) |-> (bus_rdata == '0)); // R10

  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    clc_q[0] |=> ($stable(cnt_q) && $stable(cap_q) && $stable(en_q))); // R7

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~en_q) == '0)); // R8

  for (genvar i = 0; i < N_TMR; i++) begin : g_cap
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_q[i]) |-> ($past(cnt_q[i]) == '0)); // R6
  end
endmodule

bind hex_timer_unit hex_timer_unit_chk #(.N_PAIRS(N_PAIRS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .clc_q     (clc_q),
  .cnt_q     (cnt_q),
  .cap_q     (cap_q),
  .en_q      (en_q)
);

// File: tb/hex_timer_unit_tb.sv
module hex_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  hex_timer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] tbase(input int i);
    return 8'(16 + (i / 2) * 32 + (i % 2) * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // each access starts at a negedge and consumes exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 clc reset", v, 32'h1);
    rd(8'h10, v); check("R1 ctrl reset", v, 32'h0);
    rd(8'h28, v); check("R1 count reset", v, 32'h0);
    rd(8'hFC, v); check("R1 pending reset", v, 32'h0);
    check("R1 irq reset", {26'd0, irq_o}, 32'h0);
    rd(8'h08, v); check("R2 id value", v, 32'h5900);
  endtask

  task automatic t_clock_ctrl;
    logic [31:0] v;
    wr(8'h20, 32'h33);
    rd(8'h20, v); check("R7 write blocked while off", v, 32'h0);
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h00, v); check("R7 clc mask", v, 32'h110);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R2 id write ignored", v, 32'h5900);
  endtask

  task automatic t_map;
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      wr(tbase(i), 32'hFFFF_FFFF);
      wr(tbase(i) + 8'h10, 32'h100 + 32'(i));
    end
    for (int i = 0; i < 6; i++) begin
      rd(tbase(i), v); check("R4 ctrl mask", v, 32'h5C4);
      rd(tbase(i) + 8'h10, v); check("R3 reload per timer", v, 32'h100 + 32'(i));
      wr(tbase(i), 32'h0);
    end
  endtask

  task automatic t_count;
    logic [31:0] v, a;
    wr(8'h44, 32'd5);
    wr(8'h3C, 32'h5);
    for (int k = 0; k < 6; k++) begin
      rd(8'h4C, v); check("R6 countdown", v, 32'(5 - k));
    end
    rd(8'hFC, v); check("R6 flag on wrap", v, 32'h08);
    rd(8'h4C, v); check("R6 reload after zero", v, 32'd4);
    rd(8'h3C, v); check("R5 run reads start only", v, 32'h1);
    wr(8'h3C, 32'h0);
    rd(8'h4C, a); rd(8'h4C, v); check("R5 stop holds count", v, a);
    wr(8'h4C, 32'h77);
    rd(8'h4C, v); check("R11 count read-only", v, a);
    wr(8'hFC, 32'h0);
    rd(8'hFC, v); check("R9 write 0 keeps flag", v, 32'h08);
    wr(8'hFC, 32'h08);
    rd(8'hFC, v); check("R9 write 1 clears", v, 32'h0);
    wr(8'h3C, 32'h4);
    rd(8'h4C, v); check("R5 load while stopped", v, 32'd5);
    rd(8'h3C, v); check("R5 load bit not kept", v, 32'h0);
  endtask

  task automatic t_suspend_and_off;
    logic [31:0] v, a;
    wr(8'h00, 32'h100);
    wr(8'h3C, 32'h1);
    rd(8'h4C, a); rd(8'h4C, v); check("R7 suspended no count", v, a);
    wr(8'h44, 32'd9);
    rd(8'h44, v); check("R7 suspended writes taken", v, 32'd9);
    wr(8'h00, 32'h110);
    wr(8'h00, 32'h111);
    rd(8'h4C, a); rd(8'h4C, v); check("R7 off freezes count", v, a);
    wr(8'h44, 32'd3);
    rd(8'h44, v); check("R7 off blocks reload write", v, 32'd9);
    wr(8'h00, 32'h110);
    wr(8'h3C, 32'h0);
    wr(8'hFC, 32'h3F);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(8'h20, 32'h0);
    wr(8'h18, 32'h5);
    check("R8 masked irq low", {26'd0, irq_o}, 32'h0);
    wr(8'hF4, 32'h1);
    check("R8 irq high", {26'd0, irq_o}, 32'h1);
    rd(8'hF4, v); check("R8 enable readback", v, 32'h1);
    wr(8'hFC, 32'h1);
    rd(8'hFC, v); check("R9 wrap beats clear", v, 32'h1);
    wr(8'h18, 32'h0);
    wr(8'hFC, 32'h1);
    rd(8'hFC, v); check("R9 clear after stop", v, 32'h0);
    check("R8 irq drops", {26'd0, irq_o}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(8'hF8, 32'hFFFF_FFFF);
    rd(8'hF8, v); check("R10 0xF8 reads 0", v, 32'h0);
    rd(8'h70, v); check("R10 beyond pairs", v, 32'h0);
    wr(8'h12, 32'hFFFF_FFFF);
    rd(8'h12, v); check("R10 misaligned read", v, 32'h0);
    rd(8'h10, v); check("R10 misaligned write ignored", v, 32'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clock_ctrl();
    t_map();
    t_count();
    t_suspend_and_off();
    t_irq();
    t_unmapped();
    summary();
    $finish;
  end
endmodule